// File: doc/BRIEF.md
# Register Command Packet Engine

This block turns single register requests from a host-side valid/ready handshake into command packets on a 64-bit AXI4-Stream output. After it sends a command, it waits for the response packet on a 64-bit AXI4-Stream input. It then returns the first payload word of that response as the readback value, together with the response's end-of-burst flag, time flag and timestamp.

Four operations are supported:

- **Plain write.** Carries an 8-bit register address and 32 bits of data.
- **Timed write.** Also carries a 64-bit execution time.
- **Shell read.** Sends one command that selects the readback register.
- **User-register read.** Runs two commands in a row. The first writes the user register address into a user-select register. The second selects the user readback data.

Every command carries a 12-bit command sequence number. The block keeps only one command outstanding at a time. A response whose sequence number differs from the one issued sets a sticky error flag.

Top module: `regcmd_engine`

## Requirements
- R1: Each command header word is laid out as follows: packet type 2'b10 in [63:62], time flag in [61], end-of-burst in [60] (always 0), sequence number in [59:48], byte length in [47:32], source id SRC_ID in [31:16] and destination id in [15:0]. The byte length is 8*(2+time flag), so it is 16 untimed and 24 timed. The destination id is BASE_ID plus req_port.
- R2: The last word of every command is {24'd0, addr[7:0], data[31:0]}, and it carries tlast. An untimed command is two words: header, then payload. A timed write is three words: header, then req_time, then payload, with the time flag set.
- R3: req_op encodes the operation. A value of 0 is a write of req_addr/req_data. A value of 1 is a timed write. A value of 2 is a shell read, sent as a write to register RB_SEL_REG (default 1) with data {24'd0, req_addr}.
- R4: req_op 3 is a user-register read and issues two commands. The first goes to USER_SEL_REG (default 2) with data {24'd0, req_addr | 8'h80}, which forces the address into the range 128..255. The second goes to RB_SEL_REG with data USER_RB_IDX (default 8). The readback comes from the second response.
- R5: Only one command is outstanding at a time. req_ready equals !busy. busy rises in the cycle after a request is accepted. It falls in the cycle after the tlast beat of the final response. No command word is offered while the engine is waiting for a response.
- R6: The command sequence number is 12 bits wide and starts at 0 after reset. It increments by one after every completed command, including both commands of a user read, and it wraps from 4095 to 0.
- R7: The response header holds the time flag in [61], end-of-burst in [60] and the sequence number in [59:48].
  - rsp_data is response word 1, or word 2 when the time flag is set.
  - rsp_time is word 1 when the time flag is set, and 0 otherwise.
  - Extra response words are ignored.
  - rsp_valid is a one-cycle pulse in the cycle after the final response tlast.
- R8: seq_err is set when a response sequence number differs from that of the command it answers. It stays set until reset.
- R9: While m_tvalid is high and m_tready is low, m_tvalid stays high and m_tdata stays unchanged.
- R10: During and right after reset: busy=0, req_ready=1, m_tvalid=0, s_tready=0, rsp_valid=0, seq_err=0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Request offered |
| req_ready | output | 1 | Engine idle, request taken on this edge |
| req_op | input | 2 | Operation: 0 write, 1 timed write, 2 shell read, 3 user read |
| req_addr | input | 8 | Register address (user address for op 3) |
| req_data | input | 32 | Write data |
| req_time | input | 64 | Execution time for a timed write |
| req_port | input | PORT_W | Block port added to BASE_ID |
| busy | output | 1 | Request in progress |
| rsp_valid | output | 1 | One-cycle pulse: readback fields valid |
| rsp_data | output | 64 | First payload word of the response |
| rsp_eob | output | 1 | Response end-of-burst flag |
| rsp_has_time | output | 1 | Response time flag |
| rsp_time | output | 64 | Response timestamp, 0 if absent |
| seq_err | output | 1 | Sticky sequence mismatch flag |
| m_tdata | output | 64 | Command stream data |
| m_tvalid | output | 1 | Command stream valid |
| m_tlast | output | 1 | Command stream last word |
| m_tready | input | 1 | Command stream ready |
| s_tdata | input | 64 | Response stream data |
| s_tvalid | input | 1 | Response stream valid |
| s_tlast | input | 1 | Response stream last word |
| s_tready | output | 1 | Response stream ready (high only while waiting) |

## Verification
A request is taken on the edge where req_valid meets req_ready, so the bench checks busy at the falling edge that follows. The first command word is offered from the cycle after acceptance, and the bench captures each word at the falling edge at which it drives m_tready, before the transferring edge. rsp_valid, busy release and the readback fields are registered on the edge that takes the final response tlast, so they are checked at the very next falling edge. For a user read, the same point must show rsp_valid low and busy still high, and the second command follows. The sequence number is checked in every header across more than 4096 commands, so the wrap is covered.

// File: rtl/regcmd_pkg.sv
package regcmd_pkg;

    localparam logic [1:0] PKT_TYPE_CMD = 2'b10;
    localparam int SEQ_W  = 12;
    localparam int ID_W   = 16;
    localparam int WORD_W = 64;

    typedef enum logic [1:0] {
        OP_WR       = 2'd0,
        OP_WR_TIMED = 2'd1,
        OP_RD       = 2'd2,
        OP_USER_RD  = 2'd3
    } op_e;

    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_SEND = 2'd1,
        ST_WAIT = 2'd2
    } state_e;

    // One command as issued to the serializer
    typedef struct packed {
        logic              timed;
        logic [SEQ_W-1:0]  seq;
        logic [ID_W-1:0]   dst;
        logic [7:0]        addr;
        logic [31:0]       data;
        logic [WORD_W-1:0] ts;
    } cmd_t;

    // Fields pulled out of a response packet
    typedef struct packed {
        logic              eob;
        logic              has_time;
        logic [SEQ_W-1:0]  seq;
        logic [WORD_W-1:0] ts;
        logic [WORD_W-1:0] data;
    } rsp_t;

    function automatic logic [WORD_W-1:0] cmd_header(cmd_t c, logic [ID_W-1:0] src);
        logic [15:0] len;
        len = c.timed ? 16'd24 : 16'd16;
        return {PKT_TYPE_CMD, c.timed, 1'b0, c.seq, len, src, c.dst};
    endfunction

    function automatic logic [WORD_W-1:0] cmd_payload(cmd_t c);
        return {24'd0, c.addr, c.data};
    endfunction

endpackage

// File: rtl/regcmd_tx.sv
module regcmd_tx
    import regcmd_pkg::*;
#(
    parameter logic [ID_W-1:0] SRC_ID = 16'h0010
)(
    input  logic              clk,
    input  logic              rst,
    input  logic              start,
    input  cmd_t              cmd_in,
    output logic [WORD_W-1:0] m_tdata,
    output logic              m_tvalid,
    output logic              m_tlast,
    input  logic              m_tready,
    output logic              sent
);
    localparam int IDX_W = 2;

    cmd_t             cmd_q;
    logic             active_q;
    logic [IDX_W-1:0] idx_q;
    logic [IDX_W-1:0] last_idx;

    assign last_idx = cmd_q.timed ? IDX_W'(2) : IDX_W'(1);
    assign m_tvalid = active_q;
    assign m_tlast  = active_q && (idx_q == last_idx);
    assign sent     = m_tvalid && m_tready && m_tlast;

    always_comb begin
        if (idx_q == '0)
            m_tdata = cmd_header(cmd_q, SRC_ID);
        else if (idx_q == IDX_W'(1) && cmd_q.timed)
            m_tdata = cmd_q.ts;
        else
            m_tdata = cmd_payload(cmd_q);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            cmd_q    <= '0;
            active_q <= 1'b0;
            idx_q    <= '0;
        end else if (start) begin
            cmd_q    <= cmd_in;
            active_q <= 1'b1;
            idx_q    <= '0;
        end else if (active_q && m_tready) begin
            if (m_tlast)
                active_q <= 1'b0;
            else
                idx_q <= idx_q + IDX_W'(1);
        end
    end
endmodule

// File: rtl/regcmd_rx.sv
module regcmd_rx
    import regcmd_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              en,
    input  logic [WORD_W-1:0] s_tdata,
    input  logic              s_tvalid,
    input  logic              s_tlast,
    output logic              s_tready,
    output logic              done,
    output rsp_t              rsp
);
    localparam int IDX_W = 2;
    localparam logic [IDX_W-1:0] IDX_MAX = '1;

    logic [IDX_W-1:0] idx_q;
    logic             ht_q, eob_q;
    logic [SEQ_W-1:0] seq_q;
    logic [WORD_W-1:0] ts_q, data_q;
    logic             beat, first;
    logic [IDX_W-1:0] pay_idx;
    rsp_t             cur;

    assign s_tready = en;
    assign beat     = en && s_tvalid;
    assign first    = (idx_q == '0);
    assign done     = beat && s_tlast;

    // Fields as they stand including the beat on the bus this cycle
    always_comb begin
        cur.has_time = first ? s_tdata[61] : ht_q;
        cur.eob      = first ? s_tdata[60] : eob_q;
        cur.seq      = first ? s_tdata[59:48] : seq_q;
        pay_idx      = cur.has_time ? IDX_W'(2) : IDX_W'(1);
        if (first)
            cur.ts = '0;
        else if (idx_q == IDX_W'(1) && ht_q)
            cur.ts = s_tdata;
        else
            cur.ts = ts_q;
        if (first)
            cur.data = '0;
        else if (idx_q == pay_idx)
            cur.data = s_tdata;
        else
            cur.data = data_q;
    end

    assign rsp = cur;

    always_ff @(posedge clk) begin
        if (rst) begin
            idx_q  <= '0;
            ht_q   <= 1'b0;
            eob_q  <= 1'b0;
            seq_q  <= '0;
            ts_q   <= '0;
            data_q <= '0;
        end else if (beat) begin
            if (s_tlast)
                idx_q <= '0;
            else if (idx_q != IDX_MAX)
                idx_q <= idx_q + IDX_W'(1);
            ht_q   <= cur.has_time;
            eob_q  <= cur.eob;
            seq_q  <= cur.seq;
            ts_q   <= cur.ts;
            data_q <= cur.data;
        end
    end
endmodule

// File: rtl/regcmd_engine.sv
module regcmd_engine
    import regcmd_pkg::*;
#(
    parameter logic [ID_W-1:0] SRC_ID       = 16'h0010,
    parameter logic [ID_W-1:0] BASE_ID      = 16'h0020,
    parameter int              PORT_W       = 4,
    parameter logic [7:0]      RB_SEL_REG   = 8'd1,
    parameter logic [7:0]      USER_SEL_REG = 8'd2,
    parameter logic [31:0]     USER_RB_IDX  = 32'd8
)(
    input  logic              clk,
    input  logic              rst,
    input  logic              req_valid,
    output logic              req_ready,
    input  logic [1:0]        req_op,
    input  logic [7:0]        req_addr,
    input  logic [31:0]       req_data,
    input  logic [63:0]       req_time,
    input  logic [PORT_W-1:0] req_port,
    output logic              busy,
    output logic              rsp_valid,
    output logic [63:0]       rsp_data,
    output logic              rsp_eob,
    output logic              rsp_has_time,
    output logic [63:0]       rsp_time,
    output logic              seq_err,
    output logic [63:0]       m_tdata,
    output logic              m_tvalid,
    output logic              m_tlast,
    input  logic              m_tready,
    input  logic [63:0]       s_tdata,
    input  logic              s_tvalid,
    input  logic              s_tlast,
    output logic              s_tready
);
    localparam logic [7:0] USER_ADDR_FLOOR = 8'h80;

    state_e            state_q;
    op_e               op_q, cur_op;
    logic [7:0]        addr_q, cur_addr;
    logic [31:0]       data_q, cur_data;
    logic [63:0]       time_q, cur_time;
    logic [PORT_W-1:0] port_q, cur_port;
    logic              stage_q, cur_stage;
    logic [SEQ_W-1:0]  seq_q;

    logic accept, follow_on, tx_start, tx_sent, rx_en, rx_done;
    cmd_t cmd;
    rsp_t rx_rsp;

    assign accept    = req_valid && (state_q == ST_IDLE);
    assign rx_en     = (state_q == ST_WAIT);
    assign follow_on = rx_done && (op_q == OP_USER_RD) && !stage_q;
    assign tx_start  = accept || follow_on;
    assign busy      = (state_q != ST_IDLE);
    assign req_ready = !busy;

    // Request fields come from the ports on acceptance, from the latch after
    assign cur_op    = accept ? op_e'(req_op) : op_q;
    assign cur_addr  = accept ? req_addr : addr_q;
    assign cur_data  = accept ? req_data : data_q;
    assign cur_time  = accept ? req_time : time_q;
    assign cur_port  = accept ? req_port : port_q;
    assign cur_stage = accept ? 1'b0 : 1'b1;

    always_comb begin
        cmd.timed = (cur_op == OP_WR_TIMED);
        cmd.seq   = accept ? seq_q : seq_q + SEQ_W'(1);
        cmd.dst   = BASE_ID + ID_W'(cur_port);
        cmd.ts    = cmd.timed ? cur_time : '0;
        case (cur_op)
            OP_RD: begin
                cmd.addr = RB_SEL_REG;
                cmd.data = {24'd0, cur_addr};
            end
            OP_USER_RD: begin
                if (!cur_stage) begin
                    cmd.addr = USER_SEL_REG;
                    cmd.data = {24'd0, cur_addr | USER_ADDR_FLOOR};
                end else begin
                    cmd.addr = RB_SEL_REG;
                    cmd.data = USER_RB_IDX;
                end
            end
            default: begin
                cmd.addr = cur_addr;
                cmd.data = cur_data;
            end
        endcase
    end

    regcmd_tx #(.SRC_ID(SRC_ID)) u_tx (
        .clk(clk), .rst(rst), .start(tx_start), .cmd_in(cmd),
        .m_tdata(m_tdata), .m_tvalid(m_tvalid), .m_tlast(m_tlast),
        .m_tready(m_tready), .sent(tx_sent)
    );

    regcmd_rx u_rx (
        .clk(clk), .rst(rst), .en(rx_en),
        .s_tdata(s_tdata), .s_tvalid(s_tvalid), .s_tlast(s_tlast),
        .s_tready(s_tready), .done(rx_done), .rsp(rx_rsp)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q      <= ST_IDLE;
            op_q         <= OP_WR;
            addr_q       <= '0;
            data_q       <= '0;
            time_q       <= '0;
            port_q       <= '0;
            stage_q      <= 1'b0;
            seq_q        <= '0;
            seq_err      <= 1'b0;
            rsp_valid    <= 1'b0;
            rsp_data     <= '0;
            rsp_eob      <= 1'b0;
            rsp_has_time <= 1'b0;
            rsp_time     <= '0;
        end else begin
            rsp_valid <= 1'b0;
            case (state_q)
                ST_IDLE: if (accept) begin
                    op_q    <= cur_op;
                    addr_q  <= req_addr;
                    data_q  <= req_data;
                    time_q  <= req_time;
                    port_q  <= req_port;
                    stage_q <= 1'b0;
                    state_q <= ST_SEND;
                end
                ST_SEND: if (tx_sent) state_q <= ST_WAIT;
                ST_WAIT: if (rx_done) begin
                    seq_q <= seq_q + SEQ_W'(1);
                    if (rx_rsp.seq != seq_q) seq_err <= 1'b1;
                    if (follow_on) begin
                        stage_q <= 1'b1;
                        state_q <= ST_SEND;
                    end else begin
                        rsp_valid    <= 1'b1;
                        rsp_data     <= rx_rsp.data;
                        rsp_eob      <= rx_rsp.eob;
                        rsp_has_time <= rx_rsp.has_time;
                        rsp_time     <= rx_rsp.ts;
                        state_q      <= ST_IDLE;
                    end
                end
                default: state_q <= ST_IDLE;
            endcase
        end
    end
endmodule

// File: rtl/regcmd_engine_chk.sv
module regcmd_engine_chk (
    input logic        clk,
    input logic        rst,
    input logic        busy,
    input logic        rsp_valid,
    input logic        seq_err,
    input logic [63:0] m_tdata,
    input logic        m_tvalid,
    input logic        m_tlast,
    input logic        m_tready,
    input logic        s_tvalid,
    input logic        s_tlast,
    input logic        s_tready
);
    logic in_pkt;

    always_ff @(posedge clk) begin
        if (rst)
            in_pkt <= 1'b0;
        else if (m_tvalid && m_tready)
            in_pkt <= !m_tlast;
    end

    // R1: header word carries the command type and a clear end-of-burst bit
    a_r1_hdr_type: assert property (@(posedge clk) disable iff (rst)
        (m_tvalid && !in_pkt) |-> (m_tdata[63:62] == 2'b10 && !m_tdata[60]));

    // R1: byte length follows the time flag
    a_r1_length: assert property (@(posedge clk) disable iff (rst)
        (m_tvalid && !in_pkt) |-> (m_tdata[47:32] == (m_tdata[61] ? 16'd24 : 16'd16)));

    // R5: never sending a command while waiting for a response
    a_r5_one_outstanding: assert property (@(posedge clk) disable iff (rst)
        !(m_tvalid && s_tready));

    // R5: busy only drops after a response tlast was taken
    a_r5_busy_release: assert property (@(posedge clk) disable iff (rst)
        $fell(busy) |-> $past(s_tvalid && s_tready && s_tlast));

    // R7: readback pulse follows the final response tlast
    a_r7_rsp_pulse: assert property (@(posedge clk) disable iff (rst)
        rsp_valid |-> (!busy && $past(s_tvalid && s_tready && s_tlast)));

    // R8: mismatch flag is sticky
    a_r8_sticky: assert property (@(posedge clk) disable iff (rst)
        seq_err |=> seq_err);

    // R9: stalled command word holds
    a_r9_hold: assert property (@(posedge clk) disable iff (rst)
        (m_tvalid && !m_tready) |=> (m_tvalid && $stable(m_tdata)));
endmodule

bind regcmd_engine regcmd_engine_chk u_chk (
    .clk(clk), .rst(rst), .busy(busy), .rsp_valid(rsp_valid), .seq_err(seq_err),
    .m_tdata(m_tdata), .m_tvalid(m_tvalid), .m_tlast(m_tlast), .m_tready(m_tready),
    .s_tvalid(s_tvalid), .s_tlast(s_tlast), .s_tready(s_tready)
);

// File: tb/regcmd_engine_tb_top.sv
module regcmd_engine_tb_top;
    localparam logic [15:0] SRC      = 16'h0010;
    localparam logic [15:0] BASE     = 16'h0020;
    localparam logic [7:0]  RB_SEL   = 8'd1;
    localparam logic [7:0]  USER_SEL = 8'd2;
    localparam logic [31:0] USER_IDX = 32'd8;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        req_valid = 1'b0, req_ready;
    logic [1:0]  req_op = '0;
    logic [7:0]  req_addr = '0;
    logic [31:0] req_data = '0;
    logic [63:0] req_time = '0;
    logic [3:0]  req_port = '0;
    logic        busy, rsp_valid, rsp_eob, rsp_has_time, seq_err;
    logic [63:0] rsp_data, rsp_time;
    logic [63:0] m_tdata;
    logic        m_tvalid, m_tlast, m_tready = 1'b0;
    logic [63:0] s_tdata = '0;
    logic        s_tvalid = 1'b0, s_tlast = 1'b0, s_tready;

    int          n_checks = 0, n_fails = 0;
    logic [11:0] exp_seq = '0;
    logic        exp_err = 1'b0;

    always #2 clk = ~clk;

    regcmd_engine dut_i (
        .clk(clk), .rst(rst), .req_valid(req_valid), .req_ready(req_ready),
        .req_op(req_op), .req_addr(req_addr), .req_data(req_data),
        .req_time(req_time), .req_port(req_port), .busy(busy),
        .rsp_valid(rsp_valid), .rsp_data(rsp_data), .rsp_eob(rsp_eob),
        .rsp_has_time(rsp_has_time), .rsp_time(rsp_time), .seq_err(seq_err),
        .m_tdata(m_tdata), .m_tvalid(m_tvalid), .m_tlast(m_tlast), .m_tready(m_tready),
        .s_tdata(s_tdata), .s_tvalid(s_tvalid), .s_tlast(s_tlast), .s_tready(s_tready)
    );

    task automatic check_eq(string tag, logic [63:0] act, logic [63:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fails++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    function automatic logic [63:0] exp_header(logic timed, logic [11:0] seq, logic [3:0] port);
        return {2'b10, timed, 1'b0, seq, (timed ? 16'd24 : 16'd16), SRC, BASE + {12'd0, port}};
    endfunction

    function automatic logic [63:0] exp_payload(int op, int k, logic [7:0] a, logic [31:0] d);
        case (op)
            2:       return {24'd0, RB_SEL, 24'd0, a};
            3:       return (k == 0) ? {24'd0, USER_SEL, 24'd0, a | 8'h80}
                                     : {24'd0, RB_SEL, USER_IDX};
            default: return {24'd0, a, d};
        endcase
    endfunction

    // Collect one command packet with random backpressure
    task automatic get_cmd(output logic [63:0] w [0:3], output int n);
        logic [63:0] held = '0;
        bit          hold = 0;
        n = 0;
        while (1) begin
            @(negedge clk);
            if (hold) begin
                check_eq("R9 valid held", {63'd0, m_tvalid}, 64'd1);
                check_eq("R9 data held", m_tdata, held);
            end
            m_tready = ($urandom % 4) != 0;
            if (m_tvalid && m_tready) begin
                w[n] = m_tdata;
                n++;
                hold = 0;
                if (m_tlast || n == 4) begin
                    @(posedge clk);
                    #1 m_tready = 1'b0;
                    break;
                end
            end else begin
                hold = m_tvalid;
                held = m_tdata;
            end
        end
    endtask

    task automatic send_rsp(logic [63:0] w [0:4], int n);
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            s_tvalid = 1'b1;
            s_tdata  = w[i];
            s_tlast  = (i == n - 1);
            while (!s_tready) @(negedge clk);
        end
        @(negedge clk);
        s_tvalid = 1'b0;
        s_tlast  = 1'b0;
    endtask

    task automatic access(int op, logic [7:0] a, logic [31:0] d, logic [63:0] ts,
                          logic [3:0] port, bit bad_seq);
        logic [63:0] w [0:3];
        logic [63:0] r [0:4];
        int          n, ncmd, rn;
        logic        timed, ht, eob;
        logic [63:0] rdata, rts;
        @(negedge clk);
        check_eq("R5 ready when idle", {63'd0, req_ready}, 64'd1);
        req_valid = 1'b1; req_op = 2'(op); req_addr = a; req_data = d;
        req_time = ts; req_port = port;
        @(negedge clk);
        req_valid = 1'b0;
        req_op = 2'($urandom); req_addr = 8'($urandom);
        check_eq("R5 busy after accept", {63'd0, busy}, 64'd1);
        ncmd  = (op == 3) ? 2 : 1;
        timed = (op == 1);
        for (int k = 0; k < ncmd; k++) begin
            get_cmd(w, n);
            check_eq("R2 word count", 64'(n), timed ? 64'd3 : 64'd2);
            check_eq("R1 header", w[0], exp_header(timed, exp_seq, port));
            check_eq("R6 sequence", {52'd0, w[0][59:48]}, {52'd0, exp_seq});
            if (timed) check_eq("R2 timestamp word", w[1], ts);
            check_eq((op == 3) ? "R4 user payload" : "R3 payload",
                     w[(n > 0) ? n - 1 : 0], exp_payload(op, k, a, d));
            ht    = 1'($urandom);
            eob   = 1'($urandom);
            rdata = {$urandom, $urandom};
            rts   = {$urandom, $urandom};
            r[0]  = {2'b11, ht, eob, exp_seq ^ ((bad_seq && k == ncmd - 1) ? 12'd1 : 12'd0),
                     48'($urandom)};
            rn = 1;
            if (ht) begin r[rn] = rts; rn++; end
            r[rn] = rdata; rn++;
            if ($urandom % 2 == 1) begin r[rn] = {$urandom, $urandom}; rn++; end
            send_rsp(r, rn);
            exp_seq++;
            if (bad_seq && k == ncmd - 1) exp_err = 1'b1;
            if (k < ncmd - 1) begin
                check_eq("R4 no pulse between commands", {63'd0, rsp_valid}, 64'd0);
                check_eq("R4 busy between commands", {63'd0, busy}, 64'd1);
            end else begin
                check_eq("R7 rsp_valid", {63'd0, rsp_valid}, 64'd1);
                check_eq("R5 busy released", {63'd0, busy}, 64'd0);
                check_eq("R7 rsp_data", rsp_data, rdata);
                check_eq("R7 rsp_eob", {63'd0, rsp_eob}, {63'd0, eob});
                check_eq("R7 rsp_has_time", {63'd0, rsp_has_time}, {63'd0, ht});
                check_eq("R7 rsp_time", rsp_time, ht ? rts : 64'd0);
                check_eq("R8 seq_err", {63'd0, seq_err}, {63'd0, exp_err});
            end
        end
        @(negedge clk);
        check_eq("R7 single pulse", {63'd0, rsp_valid}, 64'd0);
    endtask

    initial begin
        void'($urandom(32'd4242));
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;
        check_eq("R10 busy", {63'd0, busy}, 64'd0);
        check_eq("R10 req_ready", {63'd0, req_ready}, 64'd1);
        check_eq("R10 m_tvalid", {63'd0, m_tvalid}, 64'd0);
        check_eq("R10 s_tready", {63'd0, s_tready}, 64'd0);
        check_eq("R10 rsp_valid", {63'd0, rsp_valid}, 64'd0);
        check_eq("R10 seq_err", {63'd0, seq_err}, 64'd0);

        // directed corners
        access(0, 8'h12, 32'hDEADBEEF, 64'd0, 4'd0, 0);
        access(1, 8'h34, 32'h01234567, 64'h1122334455667788, 4'd3, 0);
        access(2, 8'h56, 32'd0, 64'd0, 4'd15, 0);
        access(3, 8'h05, 32'd0, 64'd0, 4'd1, 0);
        access(3, 8'hFF, 32'd0, 64'd0, 4'd2, 0);
        access(3, 8'h80, 32'd0, 64'd0, 4'd0, 0);

        // random traffic long enough to wrap the sequence number
        for (int i = 0; i < 4200; i++)
            access(int'($urandom % 4), 8'($urandom), $urandom, {$urandom, $urandom},
                   4'($urandom), 0);

        // mismatch, then a clean access: flag must stay set
        access(0, 8'h21, 32'hCAFE0001, 64'd0, 4'd0, 1);
        access(3, 8'h22, 32'd0, 64'd0, 4'd5, 0);
        check_eq("R8 sticky after good response", {63'd0, seq_err}, 64'd1);

        $display("[TB] %0d tests run, %0d failed", n_checks, n_fails);
        $finish;
    end

    initial begin
        repeat (190000) @(posedge clk);
        n_checks++;
        n_fails++;
        $display("FAIL watchdog expired actual=running expected=done");
        $display("[TB] %0d tests run, %0d failed", n_checks, n_fails);
        $finish;
    end
endmodule